// File: doc/BRIEF.md
# Multi-Mode 16-Bit Capture/Compare Timer

This block is a 16-bit up-counter with six operating modes: single-run, free-running, external-event counting, pulse-width modulation, plain capture and armed capture/compare. A polarity bit in the control word does two jobs. It picks which edge of the external timer input counts as a qualifying event, and it sets the level of the timer output while the timer is off and the idle level in PWM mode. Every reload and every capture produces a one-cycle interrupt pulse.

Software writes four word-wide locations through a plain write strobe: the control word, the running count, the compare limit and the PWM/capture value. The running count, the PWM/capture value and the enable state are also driven out as ports, so they can be read back. The external input is sampled through a synchroniser. In the time-based modes the count advances on a prescaled version of the system clock.

Top module: `tmr16_cc`

## Requirements
- R1: After reset the timer is disabled, with count, PWM/capture value, timer output and interrupt all 0.
- R2: A write to address 0 loads the control word. Bit 7 is enable, bits 6:4 are the mode, bits 3:1 are the prescale and bit 0 is the polarity. Address 1 loads the count, address 2 the compare value and address 3 the PWM/capture value. A count write shows on `count_o` after the edge that takes it. Mode codes are: 000 single-run, 001 free-running, 010 event-count, 011 PWM, 100 capture/compare, 101 capture.
- R3: While the timer is disabled, the output takes the polarity value on the clock edge that follows.
- R4: The input goes through a two-flop synchroniser and a previous-sample flop. Polarity 0 makes a rising edge qualifying and polarity 1 makes a falling edge qualifying. The opposite edge does nothing.
- R5: In free-running mode the count steps by one on each prescaled tick. On a tick where count equals compare, the count reloads to 1 and the output toggles. An interrupt pulse appears one cycle after the edge on which the reload happens.
- R6: Single-run mode behaves like free-running mode, except that the enable clears itself on the first reload.
- R7: Event-count mode steps the count on qualifying input edges instead of ticks. Reload and output toggling work as in R5.
- R8: In PWM mode the output moves to the inverse of polarity on a tick where count equals the PWM value, and returns to polarity on reload. With compare 8 and PWM value 3, the output is at the inverse of polarity for 5 cycles out of every 8.
- R9: In capture/compare mode the count holds until the first qualifying edge after enabling. That edge raises no interrupt.
- R10: In capture/compare mode, each qualifying edge after the first copies the count into the PWM/capture register, pulses the interrupt and sets the count to 1. With prescale 0 the captured value equals the number of cycles between the two edges.
- R11: In capture/compare mode, if no capture occurs, the count reloads to 1 with an interrupt on the tick where it equals compare.
- R12: If a capture and a compare reload fall on the same edge, the capture wins, and a single interrupt pulse results.
- R13: A tick occurs every 2^prescale cycles. The prescaler is cleared while the timer is disabled or waiting to be armed. In capture/compare mode with prescale 2, edges 20 cycles apart capture 5.
- R14: Capture mode counts from the moment it is enabled. Every qualifying edge captures and resets the count, so with prescale 0 the first capture equals 3 plus the delay in cycles between enabling and the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| tin | input | 1 | External timer input, asynchronous |
| tout | output | 1 | Timer output |
| irq | output | 1 | One-cycle interrupt pulse |
| count_o | output | 16 | Current count |
| cap_o | output | 16 | PWM/capture register |
| en_o | output | 1 | Current enable state |

## Verification
Free-running and single-run mode are run with a short compare limit. This separates a periodic reload from a reload that stops itself. PWM is run at both polarities and the duty cycle is measured over two periods, which shows whether the set and clear events are ordered and inverted correctly. The event-count and capture modes are driven with alternating rising and falling input edges, which shows whether the opposite edge is ignored. Capture/compare is tried in four ways: with gaps shorter than the compare limit, with no further edge, with a gap exactly equal to the limit, and with prescale 2. Together these separate the arming edge, the capture value, the compare reload, capture priority and the tick rate.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
   localparam int PRES_W = 3;
   localparam int MODE_W = 3;

   localparam logic [MODE_W-1:0] M_ONESHOT = 3'b000;
   localparam logic [MODE_W-1:0] M_CONT    = 3'b001;
   localparam logic [MODE_W-1:0] M_EVCNT   = 3'b010;
   localparam logic [MODE_W-1:0] M_PWM     = 3'b011;
   localparam logic [MODE_W-1:0] M_CAPCMP  = 3'b100;
   localparam logic [MODE_W-1:0] M_CAPTURE = 3'b101;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_CNT  = 2'd1;
   localparam logic [1:0] A_CMP  = 2'd2;
   localparam logic [1:0] A_PV   = 2'd3;

   localparam int EN_BIT   = 7;
   localparam int MODE_LSB = 4;
   localparam int PRES_LSB = 1;
   localparam int POL_BIT  = 0;
endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
   parameter int SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tin,
   input  logic fall_sel,
   output logic hit
);
   if (SYNC < 2) begin : g_bad_sync
      $error("tmr16_edge: SYNC must be at least 2");
   end

   logic [SYNC:0] sh;
   logic          cur, prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC-1:0], tin};
   end

   assign cur  = sh[SYNC-1];
   assign prev = sh[SYNC];
   assign hit  = fall_sel ? (prev & ~cur) : (cur & ~prev);

   // R4
   edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hit) && $stable(fall_sel)) |-> !hit);
endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
   parameter int PW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [PW-1:0] pres,
   output logic          tick
);
   if (PW < 1 || PW > 4) begin : g_bad_pw
      $error("tmr16_presc: PW must be 1..4");
   end

   localparam int PCW = (1 << PW) - 1;

   logic [PCW-1:0] pc;
   logic [PCW-1:0] mask;

   always_comb begin
      for (int i = 0; i < PCW; i++) mask[i] = (PW'(i) < pres);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pc <= '0;
      else if (run) pc <= pc + 1'b1;
      else          pc <= '0;
   end

   assign tick = run && ((pc & mask) == mask);

   // R13
   presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick) && run && $stable(pres) && pres != '0) |-> !tick);
endmodule

// File: rtl/tmr16_out.sv
module tmr16_out
   import tmr16_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              pol,
   input  logic [MODE_W-1:0] mode,
   input  logic              reload,
   input  logic              pwm_hit,
   output logic              out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out <= 1'b0;
      else if (!en) out <= pol;
      else begin
         case (mode)
            M_ONESHOT, M_CONT, M_EVCNT: if (reload) out <= ~out;
            M_PWM: begin
               if (reload)       out <= pol;
               else if (pwm_hit) out <= ~pol;
            end
            default: ;
         endcase
      end
   end

   // R3
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> (out == $past(pol)));
endmodule

// File: rtl/tmr16_cc.sv
module tmr16_cc
   import tmr16_pkg::*;
#(
   parameter int CW   = 16,
   parameter int SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [CW-1:0] wr_data,
   input  logic          tin,
   output logic          tout,
   output logic          irq,
   output logic [CW-1:0] count_o,
   output logic [CW-1:0] cap_o,
   output logic          en_o
);
   if (CW < 8) begin : g_bad_cw
      $error("tmr16_cc: CW must hold the 8-bit control word");
   end

   localparam logic [CW-1:0] ONE = CW'(1);

   logic              en_q, pol_q, armed_q, irq_q;
   logic [MODE_W-1:0] mode_q;
   logic [PRES_W-1:0] pres_q;
   logic [CW-1:0]     cnt_q, cmp_q, pv_q;

   logic wr_ctrl, wr_cnt, wr_cmp, wr_pv;
   logic is_capcmp, is_cap, is_evcnt, mode_ok;
   logic edge_hit, tick, run, count_step;
   logic cap_hit, arm_hit, at_cmp, reload, pwm_hit;

   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
   assign wr_cnt  = wr_en && (wr_addr == A_CNT);
   assign wr_cmp  = wr_en && (wr_addr == A_CMP);
   assign wr_pv   = wr_en && (wr_addr == A_PV);

   assign is_capcmp = (mode_q == M_CAPCMP);
   assign is_cap    = (mode_q == M_CAPTURE);
   assign is_evcnt  = (mode_q == M_EVCNT);
   assign mode_ok   = (mode_q <= M_CAPTURE);

   tmr16_edge #(.SYNC(SYNC)) u_edge (
      .clk(clk), .rst_n(rst_n), .tin(tin), .fall_sel(pol_q), .hit(edge_hit)
   );

   assign run = en_q && mode_ok && !is_evcnt && (!is_capcmp || armed_q);

   tmr16_presc #(.PW(PRES_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run), .pres(pres_q), .tick(tick)
   );

   assign count_step = is_evcnt ? (en_q && edge_hit) : tick;
   assign cap_hit    = en_q && edge_hit && (is_cap || (is_capcmp && armed_q));
   assign arm_hit    = en_q && edge_hit && is_capcmp && !armed_q;
   assign at_cmp     = (cnt_q == cmp_q);
   assign reload     = count_step && at_cmp && !cap_hit;
   assign pwm_hit    = count_step && (mode_q == M_PWM) && (cnt_q == pv_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         mode_q  <= '0;
         pres_q  <= '0;
         pol_q   <= 1'b0;
         cnt_q   <= '0;
         cmp_q   <= '0;
         pv_q    <= '0;
         armed_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            en_q   <= wr_data[EN_BIT];
            mode_q <= wr_data[MODE_LSB +: MODE_W];
            pres_q <= wr_data[PRES_LSB +: PRES_W];
            pol_q  <= wr_data[POL_BIT];
         end else if (reload && (mode_q == M_ONESHOT)) begin
            en_q <= 1'b0;
         end

         if (wr_cnt)                   cnt_q <= wr_data;
         else if (cap_hit || reload)   cnt_q <= ONE;
         else if (count_step)          cnt_q <= cnt_q + ONE;

         if (wr_cmp) cmp_q <= wr_data;

         if (wr_pv)        pv_q <= wr_data;
         else if (cap_hit) pv_q <= cnt_q;

         if (!en_q)        armed_q <= 1'b0;
         else if (arm_hit) armed_q <= 1'b1;

         irq_q <= cap_hit || reload;
      end
   end

   tmr16_out u_out (
      .clk(clk), .rst_n(rst_n), .en(en_q), .pol(pol_q), .mode(mode_q),
      .reload(reload), .pwm_hit(pwm_hit), .out(tout)
   );

   assign irq     = irq_q;
   assign count_o = cnt_q;
   assign cap_o   = pv_q;
   assign en_o    = en_q;

   // R9
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_capcmp && !armed_q && !wr_cnt) |=> $stable(cnt_q));

   // R11
   reload_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !$past(wr_cnt)) |-> (cnt_q == ONE));

   // R6
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && $past(mode_q == M_ONESHOT) && !$past(wr_ctrl)) |-> !en_q);
endmodule

// File: tb/tb_tmr16_cc.sv
`timescale 1ns/1ps
module tb_tmr16_cc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        tin = 1'b0;
   logic        tout, irq, en_o;
   logic [15:0] count_o, cap_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int    q_kind[$];
   int    q_val[$];
   string q_req[$];

   always #2.5 clk = ~clk;

   tmr16_cc dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tin(tin), .tout(tout), .irq(irq),
      .count_o(count_o), .cap_o(cap_o), .en_o(en_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [15:0] cv(input bit en, input logic [2:0] m,
                                      input logic [2:0] p, input bit pol);
      return {8'd0, en, m, p, pol};
   endfunction

   // kind 1: capture with value, kind 0: reload (count back to 1)
   task automatic expect_evt(input int kind, input int val, input string req);
      q_kind.push_back(kind); q_val.push_back(val); q_req.push_back(req);
   endtask

   task automatic check_drained(input string req);
      check(q_kind.size() == 0, req, q_kind.size(), 0);
   endtask

   always @(negedge clk) begin
      if (rst_n && irq && !done) begin
         if (q_kind.size() == 0) begin
            check(1'b0, "R10 unexpected irq", 1, 0);
         end else begin
            int k, v; string r;
            k = q_kind.pop_front(); v = q_val.pop_front(); r = q_req.pop_front();
            if (k == 1) check(cap_o == v[15:0], r, cap_o, v);
            else        check(count_o == 16'd1, r, count_o, 1);
         end
      end
   end

   initial begin
      repeat (30000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(tout == 1'b0, "R1 tout", tout, 0);
      check(irq == 1'b0, "R1 irq", irq, 0);
      check(count_o == 16'd0, "R1 count", count_o, 0);
      check(cap_o == 16'd0, "R1 cap", cap_o, 0);
      check(en_o == 1'b0, "R1 en", en_o, 0);

      // R2 count write readback
      wr(2'd1, 16'h1234);
      check(count_o == 16'h1234, "R2 count write", count_o, 16'h1234);

      // R3 idle output follows polarity
      wr(2'd0, cv(0, 3'b001, 3'd0, 1));
      @(negedge clk);
      check(tout == 1'b1, "R3 idle pol1", tout, 1);
      wr(2'd0, cv(0, 3'b001, 3'd0, 0));
      @(negedge clk);
      check(tout == 1'b0, "R3 idle pol0", tout, 0);

      // R5 free-running, compare 4
      wr(2'd1, 16'd1); wr(2'd2, 16'd4);
      expect_evt(0, 0, "R5 reload 1"); expect_evt(0, 0, "R5 reload 2");
      wr(2'd0, cv(1, 3'b001, 3'd0, 0));
      repeat (4) @(negedge clk);
      check(tout == 1'b1, "R5 toggle 1", tout, 1);
      check(count_o == 16'd1, "R5 count after reload", count_o, 1);
      repeat (4) @(negedge clk);
      check(tout == 1'b0, "R5 toggle 2", tout, 0);
      wr(2'd0, cv(0, 3'b001, 3'd0, 0));
      check_drained("R5 reload count");

      // R8 PWM polarity 0: compare 8, value 3
      wr(2'd1, 16'd1); wr(2'd2, 16'd8); wr(2'd3, 16'd3);
      expect_evt(0, 0, "R8 reload a"); expect_evt(0, 0, "R8 reload b");
      wr(2'd0, cv(1, 3'b011, 3'd0, 0));
      hi = 0;
      for (int i = 0; i < 16; i++) begin
         if (tout) hi++;
         @(negedge clk);
      end
      check(hi == 10, "R8 duty pol0", hi, 10);
      wr(2'd0, cv(0, 3'b011, 3'd0, 1));
      check_drained("R8 reloads pol0");

      // R8 PWM polarity 1
      wr(2'd1, 16'd1);
      expect_evt(0, 0, "R8 reload c"); expect_evt(0, 0, "R8 reload d");
      wr(2'd0, cv(1, 3'b011, 3'd0, 1));
      hi = 0;
      for (int i = 0; i < 16; i++) begin
         if (tout) hi++;
         @(negedge clk);
      end
      check(hi == 6, "R8 duty pol1", hi, 6);
      wr(2'd0, cv(0, 3'b010, 3'd0, 1));
      check_drained("R8 reloads pol1");

      // R7 / R4 event-count on falling edges, compare 3
      tin = 1'b1;
      wr(2'd1, 16'd1); wr(2'd2, 16'd3);
      repeat (5) @(negedge clk);
      wr(2'd0, cv(1, 3'b010, 3'd0, 1));
      tin = 1'b0; repeat (5) @(negedge clk);
      check(count_o == 16'd2, "R7 first fall", count_o, 2);
      tin = 1'b1; repeat (5) @(negedge clk);
      check(count_o == 16'd2, "R4 rise ignored", count_o, 2);
      tin = 1'b0; repeat (5) @(negedge clk);
      check(count_o == 16'd3, "R7 second fall", count_o, 3);
      expect_evt(0, 0, "R7 reload");
      tin = 1'b1; repeat (5) @(negedge clk);
      tin = 1'b0; repeat (5) @(negedge clk);
      check(count_o == 16'd1, "R7 count reload", count_o, 1);
      check(tout == 1'b0, "R7 output toggled", tout, 0);
      wr(2'd0, cv(0, 3'b010, 3'd0, 0));
      check_drained("R7 events");

      // R6 single-run
      wr(2'd1, 16'd1); wr(2'd2, 16'd3);
      expect_evt(0, 0, "R6 reload");
      wr(2'd0, cv(1, 3'b000, 3'd0, 0));
      repeat (10) @(negedge clk);
      check(en_o == 1'b0, "R6 enable cleared", en_o, 0);
      check(count_o == 16'd1, "R6 count stopped", count_o, 1);
      check_drained("R6 single reload");

      // R14 capture mode
      wr(2'd1, 16'd1); wr(2'd2, 16'd1000);
      expect_evt(1, 8, "R14 first capture");
      wr(2'd0, cv(1, 3'b101, 3'd0, 0));
      repeat (5) @(negedge clk);
      tin = 1'b1;
      repeat (6) @(negedge clk);
      wr(2'd0, cv(0, 3'b101, 3'd0, 0));
      tin = 1'b0;
      repeat (5) @(negedge clk);
      check_drained("R14 captures");

      // R9 / R10 / R11 capture/compare, compare 30
      wr(2'd1, 16'd1); wr(2'd2, 16'd30);
      wr(2'd0, cv(1, 3'b100, 3'd0, 0));
      repeat (10) @(negedge clk);
      check(count_o == 16'd1, "R9 held before arming", count_o, 1);
      expect_evt(1, 20, "R10 capture 20 (R9 no irq on arm)");
      tin = 1'b1; repeat (3) @(negedge clk);
      tin = 1'b0; repeat (17) @(negedge clk);
      expect_evt(1, 7, "R10 capture 7");
      tin = 1'b1; repeat (3) @(negedge clk);
      tin = 1'b0; repeat (4) @(negedge clk);
      expect_evt(0, 0, "R11 compare reload");
      tin = 1'b1; repeat (3) @(negedge clk);
      tin = 1'b0; repeat (35) @(negedge clk);
      wr(2'd0, cv(0, 3'b100, 3'd0, 0));
      check_drained("R11 events");

      // R12 capture and compare on the same edge, compare 10
      wr(2'd1, 16'd1); wr(2'd2, 16'd10);
      wr(2'd0, cv(1, 3'b100, 3'd0, 0));
      expect_evt(1, 10, "R12 capture wins");
      tin = 1'b1; repeat (3) @(negedge clk);
      tin = 1'b0; repeat (7) @(negedge clk);
      tin = 1'b1; repeat (3) @(negedge clk);
      tin = 1'b0; repeat (3) @(negedge clk);
      wr(2'd0, cv(0, 3'b100, 3'd0, 0));
      check_drained("R12 single irq");

      // R13 prescale 2
      wr(2'd1, 16'd1); wr(2'd2, 16'd1000);
      wr(2'd0, cv(1, 3'b100, 3'd2, 0));
      expect_evt(1, 5, "R13 prescaled capture");
      tin = 1'b1; repeat (3) @(negedge clk);
      tin = 1'b0; repeat (17) @(negedge clk);
      tin = 1'b1; repeat (3) @(negedge clk);
      tin = 1'b0; repeat (5) @(negedge clk);
      wr(2'd0, cv(0, 3'b100, 3'd0, 0));
      check_drained("R13 events");

      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule